// File: doc/BRIEF.md
# Stream Packet Capture with Per-Packet Record

This block watches a 64-bit packet stream and, while capture is enabled, takes a copy of every packet that passes. It keeps the leading bytes of each packet, up to a maximum byte count that can be changed at run time. It writes the kept bytes as 64-bit words into an external data FIFO. After the data words of a packet, it writes one 75-bit record into a second FIFO. The record holds the wire length, the kept length, and a latency value and an inter-packet gap value. Other logic supplies those two values on input pins, and the block only packs them.

The stream is never stalled, and packets keep flowing whether or not capture is on. The enable only changes state between packets, so a packet is always captured whole or not at all. A counter reports how many packets were captured. Two sticky flags report whether a write was ever made while the corresponding FIFO reported full.

Top module: `stream_pcap`

## Requirements
- R1: The kept length of a packet is min(wire length in bytes, cap_max_i), where cap_max_i is sampled on the packet's first beat. A value of 0 keeps no bytes.
- R2: A captured packet produces exactly ceil(kept length / 8) data-FIFO writes. Each write appears one cycle after its input beat. The record write appears two cycles after the last beat, so it always follows the packet's last data word.
- R3: Record layout: bits [23:0] latency, bit 24 latency-valid, bits [52:25] gap value, bits [63:53] wire length, bits [74:64] kept length.
- R4: A packet whose first beat arrives while capture is off causes no write to either FIFO and leaves pkt_count_o unchanged.
- R5: When no packet is in progress, cap_active_o equals cap_en_i delayed by one clock.
- R6: pkt_count_o resets to 0 and increments by one in the cycle the record of a captured packet is written, and at no other time.
- R7: err_dat_o rises the cycle after a data write is made while dat_full_i is high. It stays high until reset. With no write attempted, a high dat_full_i does not set it.
- R8: err_rec_o rises the cycle after a record write is made while rec_full_i is high, and stays high until reset.
- R9: A change of cap_en_i during a packet takes effect only after that packet's last beat. The packet keeps the capture decision made on its first beat, and cap_active_o holds during the packet.
- R10: s_tready is always 1. Every beat except the last carries 8 bytes. On the last beat, the number of set s_tkeep bits (low-aligned) is the byte count.
- R11: In written data words, byte i occupies bits [8i+7:8i]. Bytes beyond the kept length, or not flagged in the last beat's s_tkeep, are written as zero.
- R12: The latency, latency-valid and gap values in the record are those present on the packet's last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en_i | input | 1 | Capture enable request |
| cap_max_i | input | 11 | Maximum kept bytes per packet |
| s_tdata | input | 64 | Stream data, byte 0 in bits [7:0] |
| s_tkeep | input | 8 | Byte valid flags |
| s_tvalid | input | 1 | Beat valid |
| s_tlast | input | 1 | Last beat of packet |
| s_tready | output | 1 | Always 1 |
| lat_i | input | 24 | Latency value for the packet |
| lat_ok_i | input | 1 | Latency value supplied |
| gap_i | input | 28 | Inter-packet gap value |
| cap_active_o | output | 1 | Capture currently in force |
| pkt_count_o | output | 32 | Captured packet count |
| dat_wr_o | output | 1 | Data FIFO write strobe |
| dat_word_o | output | 64 | Data FIFO write word |
| dat_full_i | input | 1 | Data FIFO full |
| rec_wr_o | output | 1 | Record FIFO write strobe |
| rec_word_o | output | 75 | Record FIFO write word |
| rec_full_i | input | 1 | Record FIFO full |
| err_dat_o | output | 1 | Sticky data-FIFO overflow flag |
| err_rec_o | output | 1 | Sticky record-FIFO overflow flag |

## Verification
The bench targets packet lengths at multiples of 8 and one byte past them. It also covers limits equal to, below and above the packet length, and a limit of zero. A wrong word count or mask would show up as an extra, missing or dirty final data word, or a wrong kept-length field. It toggles the enable in the middle of packets in both directions: a design that reacted at once would emit a partial packet, or the tail of one that was never started. Back-to-back packets with no idle cycle check that the next packet's first beat does not inherit the previous packet's byte offset or limit. The overflow flags are driven with full held high both while idle and during writes. A design that flagged full alone, or cleared the flag, would be caught.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    localparam int BEAT_W = 64;
    localparam int BEAT_B = BEAT_W / 8;
    localparam int LEN_W  = 11;
    localparam int LAT_W  = 24;
    localparam int GAP_W  = 28;
    localparam int CNT_W  = 32;

    // Record word; packed MSB first so field positions follow R3.
    typedef struct packed {
        logic [LEN_W-1:0] kept_len;
        logic [LEN_W-1:0] wire_len;
        logic [GAP_W-1:0] gap;
        logic             lat_ok;
        logic [LAT_W-1:0] lat;
    } rec_t;

    localparam int REC_W = $bits(rec_t);

    // Bytes carried by one beat: full unless it is the last one.
    function automatic logic [LEN_W-1:0] beat_bytes(input logic [BEAT_B-1:0] keep,
                                                    input logic last);
        logic [LEN_W-1:0] n;
        n = '0;
        if (!last) begin
            n = LEN_W'(BEAT_B);
        end else begin
            for (int k = 0; k < BEAT_B; k++) begin
                n = n + LEN_W'(keep[k]);
            end
        end
        return n;
    endfunction

    function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pcap_gate.sv
module pcap_gate (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic beat_i,
    input  logic last_i,
    output logic take_o,
    output logic armed_o,
    output logic mid_o
);
    logic armed_q;
    logic mid_q;

    // Decision is re-sampled only when no packet is open.
    assign take_o  = mid_q ? armed_q : en_i;
    assign armed_o = armed_q;
    assign mid_o   = mid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            mid_q   <= 1'b0;
        end else begin
            armed_q <= take_o;
            if (beat_i) begin
                mid_q <= !last_i;
            end
        end
    end
endmodule

// File: rtl/pcap_beat.sv
module pcap_beat
    import pcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_i,
    input  logic              last_i,
    input  logic              first_i,
    input  logic              take_i,
    input  logic [BEAT_W-1:0] data_i,
    input  logic [BEAT_B-1:0] keep_i,
    input  logic [LEN_W-1:0]  max_i,
    input  logic [LAT_W-1:0]  lat_i,
    input  logic              lat_ok_i,
    input  logic [GAP_W-1:0]  gap_i,
    output logic              dwr_o,
    output logic [BEAT_W-1:0] dword_o,
    output logic              rec_vld_o,
    output rec_t              rec_o
);
    logic [LEN_W-1:0]  base_q, lim_q;
    logic [LEN_W-1:0]  base, lim, nbytes, total;
    logic [BEAT_B-1:0] mask;
    logic [BEAT_W-1:0] masked;
    logic              dwr_q, rec_vld_q;
    logic [BEAT_W-1:0] dword_q;
    rec_t              rec_q, rec_d;

    assign base   = first_i ? '0 : base_q;
    assign lim    = first_i ? max_i : lim_q;
    assign nbytes = beat_bytes(keep_i, last_i);
    assign total  = base + nbytes;

    for (genvar i = 0; i < BEAT_B; i++) begin : g_byte
        logic [LEN_W:0] pos;
        assign pos       = {1'b0, base} + (LEN_W+1)'(i);
        assign mask[i]   = (!last_i || keep_i[i]) && (pos < {1'b0, lim});
        assign masked[8*i +: 8] = mask[i] ? data_i[8*i +: 8] : 8'h00;
    end

    always_comb begin
        rec_d          = '0;
        rec_d.kept_len = min_len(total, lim);
        rec_d.wire_len = total;
        rec_d.gap      = gap_i;
        rec_d.lat_ok   = lat_ok_i;
        rec_d.lat      = lat_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            lim_q     <= '0;
            dwr_q     <= 1'b0;
            dword_q   <= '0;
            rec_vld_q <= 1'b0;
            rec_q     <= '0;
        end else begin
            dwr_q     <= beat_i && take_i && (|mask);
            rec_vld_q <= beat_i && take_i && last_i;
            if (beat_i) begin
                base_q  <= total;
                dword_q <= masked;
                if (last_i) begin
                    rec_q <= rec_d;
                end
                if (first_i) begin
                    lim_q <= max_i;
                end
            end
        end
    end

    assign dwr_o     = dwr_q;
    assign dword_o   = dword_q;
    assign rec_vld_o = rec_vld_q;
    assign rec_o     = rec_q;
endmodule

// File: rtl/pcap_rec.sv
module pcap_rec
    import pcap_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_i,
    input  rec_t          rec_i,
    output logic          wr_o,
    output logic [REC_W-1:0] word_o,
    output logic [CW-1:0] count_o
);
    logic             wr_q;
    logic [REC_W-1:0] word_q;
    logic [CW-1:0]    count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            word_q  <= '0;
            count_q <= '0;
        end else begin
            wr_q <= vld_i;
            if (vld_i) begin
                word_q  <= rec_i;
                count_q <= count_q + CW'(1);
            end
        end
    end

    assign wr_o    = wr_q;
    assign word_o  = word_q;
    assign count_o = count_q;
endmodule

// File: rtl/pcap_flags.sv
module pcap_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] wr_i,
    input  logic [N-1:0] full_i,
    output logic [N-1:0] err_o
);
    for (genvar c = 0; c < N; c++) begin : g_ch
        logic err_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                err_q <= 1'b0;
            end else if (wr_i[c] && full_i[c]) begin
                err_q <= 1'b1;
            end
        end
        assign err_o[c] = err_q;
    end
endmodule

// File: rtl/stream_pcap.sv
module stream_pcap
    import pcap_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en_i,
    input  logic [LEN_W-1:0]  cap_max_i,
    input  logic [BEAT_W-1:0] s_tdata,
    input  logic [BEAT_B-1:0] s_tkeep,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    input  logic [LAT_W-1:0]  lat_i,
    input  logic              lat_ok_i,
    input  logic [GAP_W-1:0]  gap_i,
    output logic              cap_active_o,
    output logic [CW-1:0]     pkt_count_o,
    output logic              dat_wr_o,
    output logic [BEAT_W-1:0] dat_word_o,
    input  logic              dat_full_i,
    output logic              rec_wr_o,
    output logic [REC_W-1:0]  rec_word_o,
    input  logic              rec_full_i,
    output logic              err_dat_o,
    output logic              err_rec_o
);
    logic take, mid_pkt, rec_vld;
    rec_t rec;
    logic [1:0] errs;

    assign s_tready = 1'b1;

    pcap_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .en_i    (cap_en_i),
        .beat_i  (s_tvalid),
        .last_i  (s_tlast),
        .take_o  (take),
        .armed_o (cap_active_o),
        .mid_o   (mid_pkt)
    );

    pcap_beat u_beat (
        .clk       (clk),
        .rst       (rst),
        .beat_i    (s_tvalid),
        .last_i    (s_tlast),
        .first_i   (!mid_pkt),
        .take_i    (take),
        .data_i    (s_tdata),
        .keep_i    (s_tkeep),
        .max_i     (cap_max_i),
        .lat_i     (lat_i),
        .lat_ok_i  (lat_ok_i),
        .gap_i     (gap_i),
        .dwr_o     (dat_wr_o),
        .dword_o   (dat_word_o),
        .rec_vld_o (rec_vld),
        .rec_o     (rec)
    );

    pcap_rec #(.CW(CW)) u_rec (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (rec_vld),
        .rec_i   (rec),
        .wr_o    (rec_wr_o),
        .word_o  (rec_word_o),
        .count_o (pkt_count_o)
    );

    pcap_flags #(.N(2)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .wr_i   ({rec_wr_o, dat_wr_o}),
        .full_i ({rec_full_i, dat_full_i}),
        .err_o  (errs)
    );

    assign err_dat_o = errs[0];
    assign err_rec_o = errs[1];
endmodule

// File: rtl/stream_pcap_checker.sv
module stream_pcap_checker
    import pcap_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             s_tready,
    input logic             cap_active_o,
    input logic             mid_pkt,
    input logic [CW-1:0]    pkt_count_o,
    input logic             dat_wr_o,
    input logic             dat_full_i,
    input logic             rec_wr_o,
    input logic             rec_full_i,
    input logic [LEN_W-1:0] kept_f,
    input logic [LEN_W-1:0] wire_f,
    input logic             err_dat_o,
    input logic             err_rec_o
);
    assert_ready_R10: assert property (@(posedge clk) disable iff (rst) s_tready);

    assert_dwr_active_R4: assert property (@(posedge clk) disable iff (rst)
        dat_wr_o |-> cap_active_o);

    assert_rec_active_R4: assert property (@(posedge clk) disable iff (rst)
        rec_wr_o |-> $past(cap_active_o));

    assert_kept_le_wire_R1: assert property (@(posedge clk) disable iff (rst)
        rec_wr_o |-> (kept_f <= wire_f));

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
        rec_wr_o |-> (pkt_count_o == CW'($past(pkt_count_o) + 1)));

    assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !rec_wr_o |-> $stable(pkt_count_o));

    assert_dat_err_set_R7: assert property (@(posedge clk) disable iff (rst)
        $past(dat_wr_o && dat_full_i) |-> err_dat_o);

    assert_dat_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        $past(err_dat_o) |-> err_dat_o);

    assert_rec_err_set_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rec_wr_o && rec_full_i) |-> err_rec_o);

    assert_rec_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        $past(err_rec_o) |-> err_rec_o);

    assert_hold_mid_R9: assert property (@(posedge clk) disable iff (rst)
        $past(mid_pkt) |-> $stable(cap_active_o));
endmodule

bind stream_pcap stream_pcap_checker #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .s_tready     (s_tready),
    .cap_active_o (cap_active_o),
    .mid_pkt      (mid_pkt),
    .pkt_count_o  (pkt_count_o),
    .dat_wr_o     (dat_wr_o),
    .dat_full_i   (dat_full_i),
    .rec_wr_o     (rec_wr_o),
    .rec_full_i   (rec_full_i),
    .kept_f       (rec_word_o[pcap_pkg::REC_W-1 -: pcap_pkg::LEN_W]),
    .wire_f       (rec_word_o[pcap_pkg::REC_W-pcap_pkg::LEN_W-1 -: pcap_pkg::LEN_W]),
    .err_dat_o    (err_dat_o),
    .err_rec_o    (err_rec_o)
);

// File: tb/stream_pcap_tb.sv
`timescale 1ns/1ps
module stream_pcap_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_en_i = 1'b0;
    logic [10:0] cap_max_i = 11'd2047;
    logic [63:0] s_tdata = '0;
    logic [7:0]  s_tkeep = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [23:0] lat_i = '0;
    logic        lat_ok_i = 1'b0;
    logic [27:0] gap_i = '0;
    logic        cap_active_o;
    logic [31:0] pkt_count_o;
    logic        dat_wr_o;
    logic [63:0] dat_word_o;
    logic        dat_full_i = 1'b0;
    logic        rec_wr_o;
    logic [74:0] rec_word_o;
    logic        rec_full_i = 1'b0;
    logic        err_dat_o;
    logic        err_rec_o;

    stream_pcap u_dut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pid    = 0;
    int exp_cnt = 0;
    bit mon_on = 1'b0;

    logic [63:0] dq_w[$];
    int          dq_c[$];
    logic [74:0] mq_w[$];
    int          mq_c[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the behavioural queues.
    always @(negedge clk) begin
        if (mon_on) begin
            if (dq_c.size() > 0 && dq_c[0] == cyc) begin
                chk(dat_wr_o == 1'b1, "R2 data write strobe", 80'(dat_wr_o), 80'd1);
                chk(dat_word_o == dq_w[0], "R11 data word", 80'(dat_word_o), 80'(dq_w[0]));
                void'(dq_c.pop_front());
                void'(dq_w.pop_front());
            end else if (dat_wr_o) begin
                chk(1'b0, "R2/R4 unexpected data write", 80'd1, 80'd0);
            end
            if (mq_c.size() > 0 && mq_c[0] == cyc) begin
                exp_cnt++;
                chk(rec_wr_o == 1'b1, "R2 record write strobe", 80'(rec_wr_o), 80'd1);
                chk(rec_word_o == mq_w[0], "R3 record word", 80'(rec_word_o), 80'(mq_w[0]));
                void'(mq_c.pop_front());
                void'(mq_w.pop_front());
            end else if (rec_wr_o) begin
                chk(1'b0, "R4 unexpected record write", 80'd1, 80'd0);
            end
            if (pkt_count_o != 32'(exp_cnt))
                chk(1'b0, "R6 packet count", 80'(pkt_count_o), 80'(exp_cnt));
        end
    end

    // Drive one packet; flip_at >= 1 toggles the enable on that beat.
    task automatic send(input int len, input int gap_after, input int flip_at);
        int nb, lim, kept;
        bit take;
        logic [74:0] m;
        nb   = (len + 7) / 8;
        lim  = int'(cap_max_i);
        kept = (len < lim) ? len : lim;
        take = cap_en_i;
        for (int b = 0; b < nb; b++) begin
            logic [63:0] w;
            bit any;
            int rem;
            @(negedge clk);
            if (b >= 1)
                chk(cap_active_o == take, "R9 active held in packet", 80'(cap_active_o), 80'(take));
            if (b == flip_at) cap_en_i = ~cap_en_i;
            rem = len - 8 * b;
            w = '0;
            any = 1'b0;
            for (int i = 0; i < 8; i++) begin
                logic [7:0] bv;
                bv = 8'(pid * 37 + 8 * b + i);
                s_tdata[8*i +: 8] = bv;
                if (8 * b + i < kept) begin
                    w[8*i +: 8] = bv;
                    any = 1'b1;
                end
            end
            s_tkeep  = (rem >= 8) ? 8'hFF : (8'hFF >> (8 - rem));
            s_tvalid = 1'b1;
            s_tlast  = (b == nb - 1);
            lat_i    = 24'(pid * 1001);
            lat_ok_i = pid[0];
            gap_i    = 28'(pid * 3 + 1);
            if (take && any) begin
                dq_c.push_back(cyc + 1);
                dq_w.push_back(w);
            end
            if (take && s_tlast) begin
                m = '0;
                m[23:0]  = 24'(pid * 1001);
                m[24]    = pid[0];
                m[52:25] = 28'(pid * 3 + 1);
                m[63:53] = 11'(len);
                m[74:64] = 11'(kept);
                mq_c.push_back(cyc + 2);
                mq_w.push_back(m);
            end
        end
        pid++;
        if (gap_after > 0) begin
            @(negedge clk);
            s_tvalid = 1'b0;
            s_tlast  = 1'b0;
            repeat (gap_after - 1) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cap_active_o == 1'b0, "R5 reset active", 80'(cap_active_o), 80'd0);
        chk(pkt_count_o == 0, "R6 reset count", 80'(pkt_count_o), 80'd0);
        chk(!dat_wr_o && !rec_wr_o, "R2 reset no writes", 80'({dat_wr_o, rec_wr_o}), 80'd0);
        chk(!err_dat_o && !err_rec_o, "R7 R8 reset flags", 80'({err_dat_o, err_rec_o}), 80'd0);
        chk(s_tready == 1'b1, "R10 ready", 80'(s_tready), 80'd1);
        mon_on = 1'b1;

        // R4: disabled, traffic passes, nothing written
        send(20, 2, -1);
        send(9, 0, -1);
        send(8, 3, -1);
        chk(pkt_count_o == 0, "R4 count frozen", 80'(pkt_count_o), 80'd0);

        // R5: enable reflected one cycle later
        cap_en_i = 1'b1;
        @(negedge clk);
        chk(cap_active_o == 1'b1, "R5 enable follows", 80'(cap_active_o), 80'd1);

        // R1 R2 R10 R11 R12: varied lengths, back-to-back
        send(1, 1, -1);
        send(8, 0, -1);
        send(9, 0, -1);
        send(64, 3, -1);
        send(100, 2, -1);
        cap_max_i = 11'd20;
        send(100, 1, -1);
        send(20, 0, -1);
        send(16, 1, -1);
        send(21, 2, -1);
        cap_max_i = 11'd0;
        send(30, 2, -1);
        cap_max_i = 11'd8;
        send(8, 0, -1);
        send(9, 2, -1);
        cap_max_i = 11'd2047;

        // R9: disable mid-packet keeps the packet; next is skipped
        send(40, 0, 2);
        send(24, 2, -1);
        idle(2);
        chk(cap_active_o == 1'b0, "R5 disable follows", 80'(cap_active_o), 80'd0);
        // R9: enable mid-packet does not capture that packet
        send(32, 0, 2);
        send(16, 3, -1);

        // R7: full without writes leaves flag low
        idle(4);
        dat_full_i = 1'b1;
        idle(5);
        chk(err_dat_o == 1'b0, "R7 no write no flag", 80'(err_dat_o), 80'd0);
        send(16, 3, -1);
        idle(2);
        chk(err_dat_o == 1'b1, "R7 overflow flagged", 80'(err_dat_o), 80'd1);
        chk(err_rec_o == 1'b0, "R8 record flag independent", 80'(err_rec_o), 80'd0);
        dat_full_i = 1'b0;
        idle(5);
        chk(err_dat_o == 1'b1, "R7 flag sticky", 80'(err_dat_o), 80'd1);

        // R8
        rec_full_i = 1'b1;
        send(8, 4, -1);
        rec_full_i = 1'b0;
        idle(3);
        chk(err_rec_o == 1'b1, "R8 overflow flagged", 80'(err_rec_o), 80'd1);

        idle(6);
        chk(dq_c.size() == 0, "R2 all data words seen", 80'(dq_c.size()), 80'd0);
        chk(mq_c.size() == 0, "R2 all records seen", 80'(mq_c.size()), 80'd0);
        chk(pkt_count_o == 32'(exp_cnt), "R6 final count", 80'(pkt_count_o), 80'(exp_cnt));
        chk(exp_cnt == 16, "R6 captured packets", 80'(exp_cnt), 80'd16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule